// File: doc/BRIEF.md
# SDRAM Command Controller with Periodic Refresh

This block sits between a simple host port and a single-data-rate SDRAM with four banks. Each bank holds 4096 rows of 512 sixteen-bit columns. The host offers one word at a time with a request/acknowledge handshake. The controller turns that word into a row open (ACTIVE) followed by a column command (READ or WRITE) that closes the row again by itself through auto precharge. Read data comes back on a strobed port once the programmed CAS latency has elapsed. Every access is a single word: the burst length is one, so the device never sees a burst stop.

After reset the block loads the device mode register once, with a burst length of one, sequential ordering and the chosen CAS latency (2 or 3). Only then does it accept host traffic. A free-running interval timer marks a refresh as due. The controller serves a due refresh before any new host request, but it never interrupts an access already under way. The minimum command spacings (mode-load to next command, row open to column command, row cycle) are parameters and are filled with NOP cycles.

The controller state machine has these states:

- `ST_MODE` issues LOAD MODE. It goes to `ST_MODE_WAIT`.
- `ST_MODE_WAIT` counts `T_MRD`. It goes to `ST_IDLE`.
- `ST_IDLE` goes to `ST_REF` when a refresh is pending. Otherwise it acknowledges a request and goes to `ST_ACT`.
- `ST_ACT` issues ACTIVE. It goes to `ST_RCD`.
- `ST_RCD` counts `T_RCD`. It goes to `ST_CMD`.
- `ST_CMD` issues READ or WRITE with auto precharge. It goes to `ST_RECOVER`.
- `ST_RECOVER` fills out `T_RC` from the ACTIVE. It goes to `ST_IDLE`.
- `ST_REF` issues AUTO REFRESH. It goes to `ST_REF_WAIT`.
- `ST_REF_WAIT` counts `T_RC`. It goes to `ST_IDLE`.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset the first command is LOAD MODE with bank 0 and an address word that has the CAS latency in bits 6:4 and zeros in bits 3:0 (burst of one, sequential). It is issued only once. No request is acknowledged, and no other command appears, until at least `T_MRD` cycles after it.
- R2: Commands are driven on {cs_n,ras_n,cas_n,we_n} with these codes: ACTIVE 0011, READ 0101, WRITE 0100, AUTO REFRESH 0001, LOAD MODE 0000 and NOP 0111. Every cycle carries one of these codes.
- R3: The host address is split as bank = bits 22:21, row = bits 20:9 and column = bits 8:0. ACTIVE carries the bank and row. READ or WRITE (according to the write flag) follows exactly `T_RCD` cycles later, to the same bank, with the column on address bits 8:0 and bit 10 high.
- R4: The data-enable output is high only in the WRITE command cycle, and the write data sits on DQ in that cycle. The byte masks are held low at all times.
- R5: The read strobe is high for exactly one cycle, `CAS_LAT`+1 cycles after the READ command cycle. It carries the word the memory presented at the `CAS_LAT`-th rising edge after that command.
- R6: The acknowledge is a single-cycle pulse given only while the request is high. The address, write flag and write data are taken in that cycle. ACTIVE follows in the next cycle and is never issued without an accepted request.
- R7: Any two commands from the set {ACTIVE, AUTO REFRESH} are at least `T_RC` cycles apart.
- R8: A refresh falls due every `REF_INTERVAL` cycles after reset. A due refresh wins over a waiting host request and is issued within `T_RC`+1 cycles of falling due, even under continuous host traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host asks for one access; held until acknowledged |
| host_ack | output | 1 | One-cycle acceptance of the request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | {bank, row, column} word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read data strobe |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address bus |
| sd_dq_out | output | 16 | Data driven to the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned by the memory |
| sd_dqm | output | 2 | Byte masks, held low |

## Verification
The bench builds the controller with a CAS latency of 3, `T_RCD` of 3, `T_RC` of 7 and a refresh interval of only 60 cycles, instead of the defaults of 2, 2, 6 and 780. The short interval makes refreshes fall due many times during a run. Some of them land while a request is held in `ST_IDLE`, and others land in the middle of an access, so the priority rule and the upper bound on refresh delay are both exercised. Latency 3 with `T_RCD` 3 makes every capture window and command gap differ from the defaults, so an off-by-one in either counter shows up in the timing checks.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_MODE,
        ST_MODE_WAIT,
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_CMD,
        ST_RECOVER,
        ST_REF,
        ST_REF_WAIT
    } ctl_state_e;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served_i,
    output logic pending_o
);
    localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick      <= TW'(INTERVAL - 1);
            pending_o <= 1'b0;
        end else if (tick == '0) begin
            tick      <= TW'(INTERVAL - 1);
            pending_o <= 1'b1;
        end else begin
            tick <= tick - 1'b1;
            if (served_i) pending_o <= 1'b0;
        end
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !served_i) |=> pending_o);

endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    logic [CAS_LAT-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe    <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            pipe    <= {pipe[CAS_LAT-2:0], issue_i};
            valid_o <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1]) data_o <= dq_i;
        end
    end

    // R5
    rvalid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(issue_i, CAS_LAT + 1));

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 16,
    parameter int CAS_LAT      = 2,
    parameter int T_MRD        = 2,
    parameter int T_RCD        = 2,
    parameter int T_RC         = 6,
    parameter int REF_INTERVAL = 780
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_req,
    output logic                            host_ack,
    input  logic                            host_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]               host_wdata,
    output logic [DATA_W-1:0]               host_rdata,
    output logic                            host_rvalid,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in,
    output logic [DATA_W/8-1:0]             sd_dqm
);
    localparam int ADDR_W   = BANK_W + ROW_W + COL_W;
    localparam int AP_BIT   = 10;
    localparam int WAIT_MAX = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1) + 1;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    ctl_state_e state, state_nx;
    logic [CNT_W-1:0] wait_cnt, wait_nx;
    sd_cmd_e cmd;

    logic [BANK_W-1:0] acc_bank;
    logic [ROW_W-1:0]  acc_row;
    logic [COL_W-1:0]  acc_col;
    logic              acc_we;
    logic [DATA_W-1:0] acc_wdata;
    logic              ref_pend;

    // Next state and handshake
    always_comb begin
        state_nx = state;
        wait_nx  = wait_cnt;
        host_ack = 1'b0;
        unique case (state)
            ST_MODE: begin
                state_nx = ST_MODE_WAIT;
                wait_nx  = CNT_W'(T_MRD - 2);
            end
            ST_MODE_WAIT: begin
                if (wait_cnt == '0) state_nx = ST_IDLE;
                else                wait_nx  = wait_cnt - 1'b1;
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    state_nx = ST_REF;
                end else if (host_req) begin
                    host_ack = 1'b1;
                    state_nx = ST_ACT;
                end
            end
            ST_ACT: begin
                state_nx = ST_RCD;
                wait_nx  = CNT_W'(T_RCD - 2);
            end
            ST_RCD: begin
                if (wait_cnt == '0) state_nx = ST_CMD;
                else                wait_nx  = wait_cnt - 1'b1;
            end
            ST_CMD: begin
                state_nx = ST_RECOVER;
                wait_nx  = CNT_W'(T_RC - T_RCD - 2);
            end
            ST_RECOVER: begin
                if (wait_cnt == '0) state_nx = ST_IDLE;
                else                wait_nx  = wait_cnt - 1'b1;
            end
            ST_REF: begin
                state_nx = ST_REF_WAIT;
                wait_nx  = CNT_W'(T_RC - 2);
            end
            ST_REF_WAIT: begin
                if (wait_cnt == '0) state_nx = ST_IDLE;
                else                wait_nx  = wait_cnt - 1'b1;
            end
            default: state_nx = ST_MODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_MODE;
            wait_cnt <= '0;
        end else begin
            state    <= state_nx;
            wait_cnt <= wait_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_bank  <= '0;
            acc_row   <= '0;
            acc_col   <= '0;
            acc_we    <= 1'b0;
            acc_wdata <= '0;
        end else if (host_ack) begin
            acc_bank  <= host_addr[ADDR_W-1 -: BANK_W];
            acc_row   <= host_addr[COL_W +: ROW_W];
            acc_col   <= host_addr[0 +: COL_W];
            acc_we    <= host_we;
            acc_wdata <= host_wdata;
        end
    end

    // Memory-side outputs
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = acc_bank;
        sd_addr  = '0;
        sd_dq_oe = 1'b0;
        unique case (state)
            ST_MODE: begin
                cmd     = CMD_MRS;
                sd_ba   = '0;
                sd_addr = MODE_WORD;
            end
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = acc_row;
            end
            ST_CMD: begin
                cmd                   = acc_we ? CMD_WR : CMD_RD;
                sd_addr[COL_W-1:0]    = acc_col;
                sd_addr[AP_BIT]       = 1'b1;
                sd_dq_oe              = acc_we;
            end
            ST_REF: cmd = CMD_REF;
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_out = acc_wdata;
    assign sd_dqm    = '0;

    sdram_ref_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_ref_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .served_i  (state == ST_REF),
        .pending_o (ref_pend)
    );

    sdram_read_capture #(
        .CAS_LAT (CAS_LAT),
        .DATA_W  (DATA_W)
    ) u_read_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i ((state == ST_CMD) && !acc_we),
        .dq_i    (sd_dq_in),
        .data_o  (host_rdata),
        .valid_o (host_rvalid)
    );

    // Cycles since the last row-occupying command (checker support)
    logic [CNT_W-1:0] since_row;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   since_row <= CNT_W'(WAIT_MAX);
        else if (cmd == CMD_ACT || cmd == CMD_REF)    since_row <= CNT_W'(1);
        else if (since_row < CNT_W'(WAIT_MAX))        since_row <= since_row + 1'b1;
    end

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (since_row == CNT_W'(T_RCD)));

    // R7
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> (since_row >= CNT_W'(T_RC)));

    // R6
    ack_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (cmd == CMD_ACT && !host_ack));

    // R8
    ref_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_pend) |-> $past(cmd == CMD_REF));

endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb_top;
    localparam int BANK_W = 2, ROW_W = 12, COL_W = 9, DATA_W = 16;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int CL = 3, TMRD = 2, TRCD = 3, TRC = 7, REFI = 60;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011;
    localparam logic [3:0] C_WR  = 4'b0100, C_RD  = 4'b0101, C_NOP = 4'b0111;
    localparam logic [ROW_W-1:0] MODE_EXP = ROW_W'(CL << 4);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic host_req, host_ack, host_we, host_rvalid;
    logic [ADDR_W-1:0] host_addr;
    logic [DATA_W-1:0] host_wdata, host_rdata;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic [DATA_W-1:0] sd_dq_out, sd_dq_in;
    logic [1:0] sd_dqm;

    sdram_cmd_ctrl #(
        .CAS_LAT(CL), .T_MRD(TMRD), .T_RCD(TRCD), .T_RC(TRC), .REF_INTERVAL(REFI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_ack(host_ack), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    wire [3:0] pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input int k);
        return 16'((k * 40503) ^ (k >>> 5) ^ 16'h5A3C);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Behavioural memory
    logic [15:0] mem [int];
    logic [ROW_W-1:0] mrow [4];
    int rd_dly = 0, rd_key = 0;
    logic [15:0] nxt_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_dly = 0;
            sd_dq_in <= 16'h0BAD;
        end else begin
            nxt_q = 16'h0BAD;
            if (rd_dly > 0) begin
                rd_dly--;
                if (rd_dly == 0) nxt_q = mem.exists(rd_key) ? mem[rd_key] : pattern(rd_key);
            end
            case (pins)
                C_ACT: mrow[sd_ba] = sd_addr;
                C_WR:  mem[int'({sd_ba, mrow[sd_ba], sd_addr[COL_W-1:0]})] = sd_dq_out;
                C_RD: begin
                    rd_key = int'({sd_ba, mrow[sd_ba], sd_addr[COL_W-1:0]});
                    rd_dly = CL - 1;
                end
                default: ;
            endcase
            sd_dq_in <= nxt_q;
        end
    end

    // Current host operation, shared with the monitor
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    bit cur_we, op_live = 0, seen_mrs = 0, prev_ack = 0;
    int act_cyc = -100, row_cyc = -100, rd_exp = -1, ref_idx = 0, last_ack_cyc = 0;
    logic [15:0] shadow [int];

    // Command monitor
    always @(negedge clk) if (rst_n) begin
        chk(pins inside {C_MRS, C_REF, C_ACT, C_WR, C_RD, C_NOP}, "R2", "command code", pins, C_NOP);
        if (!seen_mrs) begin
            chk(pins == C_MRS && cyc == 0, "R1", "first command", pins, C_MRS);
            chk(sd_addr == MODE_EXP && sd_ba == 0, "R1", "mode word", sd_addr, MODE_EXP);
            seen_mrs = 1;
        end else begin
            case (pins)
                C_MRS: chk(0, "R1", "repeated LOAD MODE", pins, C_NOP);
                C_ACT: begin
                    chk(op_live, "R6", "ACTIVE without request", 0, 1);
                    chk(cyc >= TMRD, "R1", "ACTIVE after mode load", cyc, TMRD);
                    chk(cyc - row_cyc >= TRC, "R7", "ACTIVE spacing", cyc - row_cyc, TRC);
                    chk(sd_ba == cur_addr[22:21] && sd_addr == cur_addr[20:9], "R3",
                        "bank/row", {sd_ba, sd_addr}, cur_addr[22:9]);
                    op_live = 0; act_cyc = cyc; row_cyc = cyc;
                end
                C_RD, C_WR: begin
                    chk(cyc - act_cyc == TRCD, "R3", "ACTIVE to column gap", cyc - act_cyc, TRCD);
                    chk(pins == (cur_we ? C_WR : C_RD), "R3", "direction", pins, cur_we ? C_WR : C_RD);
                    chk(sd_addr[10] == 1'b1, "R3", "auto precharge bit", sd_addr[10], 1);
                    chk(sd_ba == cur_addr[22:21] && sd_addr[8:0] == cur_addr[8:0], "R3",
                        "bank/column", {sd_ba, sd_addr[8:0]}, {cur_addr[22:21], cur_addr[8:0]});
                    if (pins == C_WR)
                        chk(sd_dq_oe && sd_dq_out == cur_wdata, "R4", "write data", sd_dq_out, cur_wdata);
                    else
                        rd_exp = cyc + CL + 1;
                end
                C_REF: begin
                    chk(cyc >= (ref_idx + 1) * REFI + 1 && cyc <= (ref_idx + 1) * REFI + TRC + 2,
                        "R8", "refresh time", cyc, (ref_idx + 1) * REFI + 1);
                    chk(cyc - row_cyc >= TRC, "R7", "refresh spacing", cyc - row_cyc, TRC);
                    ref_idx++; row_cyc = cyc;
                end
                default: ;
            endcase
        end
        if (pins != C_WR) chk(!sd_dq_oe, "R4", "data enable outside write", sd_dq_oe, 0);
        chk(sd_dqm == 2'b00, "R4", "byte masks", sd_dqm, 0);
        if (host_rvalid || cyc == rd_exp)
            chk(host_rvalid && cyc == rd_exp, "R5", "read strobe cycle", cyc, rd_exp);
        if (host_ack) chk(host_req && !prev_ack, "R6", "ack pulse", {host_req, prev_ack}, 2'b10);
        prev_ack = host_ack;
    end

    task automatic host_op(input bit we, input logic [ADDR_W-1:0] a, input logic [15:0] d);
        int g = 0;
        logic [15:0] exp;
        cur_we = we; cur_addr = a; cur_wdata = d;
        host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1; op_live = 1;
        exp = shadow.exists(int'(a)) ? shadow[int'(a)] : pattern(int'(a));
        while (1) begin
            #1;
            if (host_ack) break;
            @(negedge clk);
            g++;
            if (g > 200) begin chk(0, "R6", "ack timeout", 0, 1); break; end
        end
        last_ack_cyc = cyc;
        @(negedge clk);
        host_req = 1'b0;
        repeat (TRCD + 1) @(negedge clk);
        if (we) begin
            shadow[int'(a)] = d;
        end else begin
            g = 0;
            while (!host_rvalid && g < 40) begin @(negedge clk); g++; end
            chk(host_rvalid && host_rdata == exp, "R5", "read data", host_rdata, exp);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [ADDR_W-1:0] pool [8];

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        cur_addr = '0; cur_wdata = '0; cur_we = 0;
        repeat (3) @(negedge clk);
        // Reset state
        chk(!host_ack, "R6", "ack in reset", host_ack, 0);
        chk(!host_rvalid, "R5", "rvalid in reset", host_rvalid, 0);
        chk(!sd_dq_oe, "R4", "data enable in reset", sd_dq_oe, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: request pending from release waits for mode load
        host_op(1, 23'h7F_FFFF, 16'hBEEF);
        chk(last_ack_cyc >= TMRD, "R1", "first ack cycle", last_ack_cyc, TMRD);

        // Directed corners
        host_op(0, 23'h7F_FFFF, 0);
        host_op(0, 23'h00_0000, 0);
        host_op(1, 23'h00_0000, 16'h1234);
        host_op(0, 23'h00_0000, 0);
        host_op(1, {2'd2, 12'hABC, 9'h155}, 16'h0F0F);
        host_op(0, {2'd2, 12'hABC, 9'h155}, 0);

        // Back-to-back writes across refresh due points
        for (int i = 0; i < 24; i++)
            host_op(1, {2'(i), 12'(i * 37), 9'(i * 11)}, 16'(i * 4099));
        for (int i = 0; i < 24; i++)
            host_op(0, {2'(i), 12'(i * 37), 9'(i * 11)}, 0);

        // Idle: only refreshes may appear
        repeat (200) @(negedge clk);

        // Constrained random
        for (int i = 0; i < 8; i++) pool[i] = ADDR_W'($urandom);
        for (int i = 0; i < 90; i++) begin
            logic [ADDR_W-1:0] a;
            bit we;
            a  = ($urandom % 3 == 0) ? ADDR_W'($urandom) : pool[$urandom % 8];
            we = $urandom % 2;
            host_op(we, a, 16'($urandom));
            if ($urandom % 4 == 0) repeat ($urandom % 30) @(negedge clk);
        end

        repeat (20) @(negedge clk);
        chk(ref_idx >= (cyc - TRC - 2) / REFI && ref_idx <= cyc / REFI, "R8",
            "refresh count", ref_idx, cyc / REFI);
        finish_run();
    end
endmodule